// File: doc/BRIEF.md
# Gated Prescaled Period Timer

This block is a 16-bit up-counting timer peripheral with three software registers: a control word, a live count and a period limit. Each count step comes from one of two sources. The first is an internal tick enable that runs at instruction rate. The second is a rising edge on an external clock pin, which is either resynchronised or taken through a shorter path. The chosen step stream passes through a prescaler with a ratio of 1, 8, 64 or 256. When the count reaches the period value it returns to zero and a sticky event flag is raised. The flag can drive an interrupt request.

A gate option makes the timer measure a pulse width. Internal ticks advance the timer only while a gate pin is high. Two power-mode inputs, idle and sleep, freeze or allow counting according to the control settings. Any register write that changes the count or the configuration restarts the prescaler so that the next count step comes a full ratio later. A control write never changes the count. The prescaler is only cleared while the timer is enabled, or by the write that enables it.

Top module: `gated_period_timer`

## Requirements
- R1: After synchronous reset the control reads 0x0000, the count 0x0000, the period 0xFFFF, the status 0x0000, and event_flag and irq are low.
- R2: Addresses are 0 control, 1 count, 2 period and 3 status (bit 0 = event flag). Control fields are: bit 15 enable, bit 13 stop-in-idle, bit 6 gate, bits 5:4 prescale, bit 3 interrupt enable, bit 2 synchronise, bit 1 external source. All other control bits read 0. rd_data shows the register selected by rd_addr one clock later.
- R3: Prescale codes 0, 1, 2 and 3 give one count step per 1, 8, 64 and 256 qualified ticks.
- R4: A count step taken while count equals period loads 0 and sets the event flag. The flag stays set until a status write with bit 0 = 0. If that write falls in the same cycle as a match, the flag stays set. Writing 1 never sets the flag.
- R5: irq is high exactly when the event flag and the interrupt-enable bit are both 1.
- R6: A control write leaves the count unchanged and restarts the prescaler. A count write loads the count, restarts the prescaler, and takes priority over a count step in the same cycle.
- R7: With the gate bit set and the internal source selected, ticks count only while gate_in is high. With the external source selected, gate_in has no effect.
- R8: With the external source selected, each rising edge of ext_clk is one tick and a falling edge is not. With synchronise = 1 the count changes on the third clock edge after ext_clk rises. With synchronise = 0 it changes on the second clock edge.
- R9: While idle_mode is high and stop-in-idle = 1 the count holds, and counting resumes when idle ends. With stop-in-idle = 0 counting continues through idle.
- R10: While sleep_mode is high the timer counts only if it is enabled, the external source is selected and synchronise = 0.
- R11: With enable = 0, neither ticks nor external edges change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Internal instruction-rate tick enable |
| ext_clk | input | 1 | External clock input, sampled |
| gate_in | input | 1 | Gate for pulse-width accumulation |
| idle_mode | input | 1 | Core idle indication |
| sleep_mode | input | 1 | Core sleep indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| event_flag | output | 1 | Sticky period-match flag |
| irq | output | 1 | Interrupt request |

## Verification
The prescaler ratios and the period wrap are swept over many tick counts, and each result is compared with integer division or a modulo in the bench. An off-by-one terminal count or a wrap one step late would show up in this sweep. Restart after a write is checked with partial prescaler counts. A design that kept the partial count would step early, and one that cleared the count on a control write would lose its value. Same-cycle collisions, meaning a load against a step and a flag clear against a match, expose any reversed priority. The ext_clk latency is checked cycle by cycle, so a synchroniser that is too short or too long is caught. The gate, idle and sleep sweeps catch a power or gate qualifier applied to the wrong source.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CTRL_W     = 16;
  localparam int BIT_EN     = 15;
  localparam int BIT_SIDL   = 13;
  localparam int BIT_GATE   = 6;
  localparam int BIT_PS_LO  = 4;
  localparam int BIT_IE     = 3;
  localparam int BIT_SYNC   = 2;
  localparam int BIT_SRC    = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hA07E;
  localparam int PRE_W      = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_PERIOD = 2'd2,
    ADDR_STATUS = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PS_1   = 2'd0,
    PS_8   = 2'd1,
    PS_64  = 2'd2,
    PS_256 = 2'd3
  } ps_sel_e;

  typedef struct packed {
    logic    en;
    logic    stop_idle;
    logic    gate;
    logic    ie;
    logic    sync;
    logic    src_ext;
    ps_sel_e ps;
  } ctrl_t;

  function automatic logic [PRE_W-1:0] ps_limit(input ps_sel_e ps);
    case (ps)
      PS_1:    ps_limit = PRE_W'(0);
      PS_8:    ps_limit = PRE_W'(7);
      PS_64:   ps_limit = PRE_W'(63);
      default: ps_limit = PRE_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/gpt_tick_source.sv
module gpt_tick_source
  import gpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick_in,
  input  logic  ext_clk,
  input  logic  gate_in,
  input  logic  idle_mode,
  input  logic  sleep_mode,
  input  ctrl_t ctrl,
  output logic  cnt_tick
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] stg;
  logic sync_edge, async_edge, raw_tick, sleep_ok, run;

  // stg[0] is the first sampling flop; higher indexes are older samples
  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[CHAIN-2:0], ext_clk};
  end

  assign sync_edge  = stg[SYNC_STAGES-1] & ~stg[SYNC_STAGES];
  assign async_edge = stg[0] & ~stg[1];

  always_comb begin
    if (ctrl.src_ext)
      raw_tick = ctrl.sync ? sync_edge : async_edge;
    else
      raw_tick = tick_in & (~ctrl.gate | gate_in);
  end

  assign sleep_ok = ctrl.src_ext & ~ctrl.sync;
  assign run      = ctrl.en & (sleep_mode ? sleep_ok : ~(idle_mode & ctrl.stop_idle));
  assign cnt_tick = run & raw_tick;

  // R8: an external edge is a single-cycle event
  assert_edge_single_R8: assert property (@(posedge clk) disable iff (rst)
    sync_edge |=> !sync_edge);
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler
  import gpt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    adv,
  input  ps_sel_e ps,
  output logic    step
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;
  logic             at_limit;

  assign limit    = ps_limit(ps);
  assign at_limit = (pre_cnt >= limit);
  assign step     = adv & ~clr & at_limit;

  always_ff @(posedge clk) begin
    if (rst)      pre_cnt <= '0;
    else if (clr) pre_cnt <= '0;
    else if (adv) pre_cnt <= at_limit ? '0 : pre_cnt + 1'b1;
  end

  assert_prescale_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    step |=> pre_cnt == '0);
  assert_prescale_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> pre_cnt == '0);
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic hit;
  assign hit   = (count == period);
  assign match = step & ~load & hit;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= hit ? '0 : count + 1'b1;
  end

  assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
  assert_match_zero_R4: assert property (@(posedge clk) disable iff (rst)
    match |=> count == '0);
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             ext_clk,
  input  logic             gate_in,
  input  logic             idle_mode,
  input  logic             sleep_mode,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             event_flag,
  output logic             irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  period_q;
  logic [CNT_W-1:0]  count_q;
  logic              flag_q;
  ctrl_t             ctrl;
  logic              wr_ctrl, wr_cnt, wr_per, wr_stat;
  logic              pre_clr, cnt_tick, step, match;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == ADDR_COUNT);
  assign wr_per  = wr_en && (wr_addr == ADDR_PERIOD);
  assign wr_stat = wr_en && (wr_addr == ADDR_STATUS);

  assign ctrl.en        = ctrl_q[BIT_EN];
  assign ctrl.stop_idle = ctrl_q[BIT_SIDL];
  assign ctrl.gate      = ctrl_q[BIT_GATE];
  assign ctrl.ie        = ctrl_q[BIT_IE];
  assign ctrl.sync      = ctrl_q[BIT_SYNC];
  assign ctrl.src_ext   = ctrl_q[BIT_SRC];
  assign ctrl.ps        = ps_sel_e'(ctrl_q[BIT_PS_LO+1:BIT_PS_LO]);

  // the prescaler clock runs only while enabled; the enabling write restarts it
  assign pre_clr = (wr_ctrl & (ctrl_q[BIT_EN] | wr_data[BIT_EN])) |
                   (wr_cnt & ctrl_q[BIT_EN]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q   <= wr_data[CTRL_W-1:0] & CTRL_MASK;
      if (wr_per)  period_q <= wr_data;
      if (match)                     flag_q <= 1'b1;
      else if (wr_stat & ~wr_data[0]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_CTRL:   rd_data <= CNT_W'(ctrl_q);
        ADDR_COUNT:  rd_data <= count_q;
        ADDR_PERIOD: rd_data <= period_q;
        default:     rd_data <= CNT_W'(flag_q);
      endcase
    end
  end

  assign event_flag = flag_q;
  assign irq        = flag_q & ctrl.ie;

  gpt_tick_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_clk(ext_clk),
    .gate_in(gate_in), .idle_mode(idle_mode), .sleep_mode(sleep_mode),
    .ctrl(ctrl), .cnt_tick(cnt_tick)
  );

  gpt_prescaler u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .adv(cnt_tick), .ps(ctrl.ps), .step(step)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_cnt), .load_val(wr_data), .step(step),
    .period(period_q), .count(count_q), .match(match)
  );

  assert_ctrl_keeps_count_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> $stable(count_q));
  assert_off_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[BIT_EN] && !wr_cnt) |=> $stable(count_q));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (idle_mode && !sleep_mode && ctrl_q[BIT_SIDL] && !wr_cnt) |=> $stable(count_q));
  assert_sleep_rule_R10: assert property (@(posedge clk) disable iff (rst)
    (sleep_mode && !(ctrl_q[BIT_SRC] && !ctrl_q[BIT_SYNC]) && !wr_cnt) |=> $stable(count_q));
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    match |=> flag_q);
endmodule

// File: tb/tb_gated_period_timer.sv
module tb_gated_period_timer;
  localparam int W = 16;
  localparam logic [15:0] EN = 16'h8000, SIDL = 16'h2000, GATE = 16'h0040,
                          IE = 16'h0008, SYNC = 16'h0004, SRC = 16'h0002;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_in = 0, ext_clk = 0, gate_in = 0, idle_mode = 0, sleep_mode = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] rd_data;
  logic event_flag, irq;
  int checks = 0, fails = 0;
  logic [15:0] v;

  always #4 clk = ~clk;

  gated_period_timer dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_clk(ext_clk), .gate_in(gate_in),
    .idle_mode(idle_mode), .sleep_mode(sleep_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .event_flag(event_flag), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick_in = 1; end
    @(negedge clk); tick_in = 0;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk = 1;
    repeat (3) @(negedge clk);
    ext_clk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] c);
    wr(0, c); wr(1, 0); wr(3, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 16'h0000);
    rd(1, v); check("R1 count", v, 16'h0000);
    rd(2, v); check("R1 period", v, 16'hFFFF);
    rd(3, v); check("R1 status", v, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);

    // R2 register map and masking
    wr(0, 16'hFFFF); rd(0, v); check("R2 ctrl mask", v, 16'hA07E);
    wr(2, 16'h1234); rd(2, v); check("R2 period", v, 16'h1234);
    wr(1, 16'h0042); rd(1, v); check("R2 count", v, 16'h0042);
    wr(0, 0);

    // R3 prescale ratios
    wr(2, 16'hFFFF);
    for (int ps = 0; ps < 4; ps++) begin
      int r;
      r = (ps == 3) ? 256 : (1 << (3 * ps));
      setup(EN | 16'(ps << 4));
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (k == 0) ? r - 1 : (k == 1) ? r : 3 * r + r - 1;
        wr(1, 0); ticks(n); rd(1, v); check("R3 ratio", v, 16'(n / r));
      end
    end
    setup(EN | 16'h0010);
    for (int n = 0; n <= 20; n++) begin
      wr(1, 0); ticks(n); rd(1, v); check("R3 ratio 8 sweep", v, 16'(n / 8));
    end

    // R4 period wrap and sticky flag
    setup(EN);
    for (int pi = 0; pi < 4; pi++) begin
      int p;
      p = (pi == 3) ? 5 : pi;
      wr(2, 16'(p));
      for (int n = 0; n <= 2 * p + 3; n++) begin
        wr(1, 0); wr(3, 0); ticks(n);
        rd(1, v); check("R4 wrap count", v, 16'(n % (p + 1)));
        rd(3, v); check("R4 flag", v, (n > p) ? 16'h1 : 16'h0);
      end
    end
    wr(2, 16'h0003);
    wr(3, 16'h0001); rd(3, v); check("R4 write 1 keeps flag", v, 16'h1);
    wr(3, 0); rd(3, v); check("R4 clear", v, 16'h0);
    wr(3, 16'h0001); rd(3, v); check("R4 write 1 no set", v, 16'h0);
    ticks(4); rd(3, v); check("R4 flag set", v, 16'h1);
    wr(1, 16'h0003);
    @(negedge clk); tick_in = 1; wr_en = 1; wr_addr = 3; wr_data = 0;
    @(negedge clk); tick_in = 0; wr_en = 0;
    rd(3, v); check("R4 match beats clear", v, 16'h1);
    rd(1, v); check("R4 match count zero", v, 16'h0);

    // R5 interrupt request
    @(negedge clk); check("R5 irq masked", {15'b0, irq}, 16'h0);
    wr(0, EN | IE); @(negedge clk); check("R5 irq on", {15'b0, irq}, 16'h1);
    wr(3, 0); @(negedge clk); check("R5 irq off", {15'b0, irq}, 16'h0);

    // R6 write side effects
    wr(2, 16'hFFFF); setup(EN | 16'h0010);
    wr(1, 16'h0300); ticks(5); wr(0, EN | 16'h0010);
    rd(1, v); check("R6 ctrl keeps count", v, 16'h0300);
    ticks(7); rd(1, v); check("R6 ctrl restarts prescaler", v, 16'h0300);
    ticks(1); rd(1, v); check("R6 step after restart", v, 16'h0301);
    ticks(5); wr(1, 16'h0010); ticks(7); rd(1, v); check("R6 count write restarts", v, 16'h0010);
    ticks(1); rd(1, v); check("R6 step after load", v, 16'h0011);
    setup(EN);
    @(negedge clk); tick_in = 1; wr_en = 1; wr_addr = 1; wr_data = 16'h0050;
    @(negedge clk); tick_in = 0; wr_en = 0;
    rd(1, v); check("R6 load beats step", v, 16'h0050);

    // R7 gated accumulation
    setup(EN | GATE);
    begin
      logic [7:0] lfsr;
      int exp;
      lfsr = 8'hA5; exp = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        gate_in = lfsr[0]; tick_in = (i % 3) != 0;
        if (lfsr[0] && (i % 3) != 0) exp++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      @(negedge clk); tick_in = 0; gate_in = 0;
      rd(1, v); check("R7 gated count", v, 16'(exp));
    end
    setup(EN | GATE | SRC | SYNC);
    gate_in = 0;
    repeat (5) ext_pulse();
    rd(1, v); check("R7 gate ignored ext", v, 16'h5);

    // R8 external edge latency
    setup(EN | SRC);
    @(negedge clk); rd_addr = 1; ext_clk = 1;
    @(negedge clk); check("R8 async e1", rd_data, 16'h0);
    @(negedge clk); check("R8 async e2", rd_data, 16'h0);
    @(negedge clk); check("R8 async e3", rd_data, 16'h1);
    ext_clk = 0; repeat (4) @(negedge clk);
    check("R8 fall no count", rd_data, 16'h1);
    setup(EN | SRC | SYNC);
    @(negedge clk); rd_addr = 1; ext_clk = 1;
    @(negedge clk); @(negedge clk);
    @(negedge clk); check("R8 sync e3", rd_data, 16'h0);
    @(negedge clk); check("R8 sync e4", rd_data, 16'h1);
    ext_clk = 0; repeat (4) @(negedge clk);
    setup(EN | SRC | SYNC | 16'h0010);
    repeat (17) ext_pulse();
    rd(1, v); check("R8 ext prescaled", v, 16'h2);

    // R9 idle behaviour
    setup(EN | SIDL);
    idle_mode = 1; ticks(10); rd(1, v); check("R9 idle frozen", v, 16'h0);
    idle_mode = 0; ticks(10); rd(1, v); check("R9 resume", v, 16'd10);
    setup(EN);
    idle_mode = 1; ticks(10); idle_mode = 0; rd(1, v); check("R9 idle runs", v, 16'd10);

    // R10 sleep behaviour
    sleep_mode = 1;
    setup(EN); ticks(10); rd(1, v); check("R10 internal sleeps", v, 16'h0);
    setup(EN | SRC | SYNC); repeat (3) ext_pulse(); rd(1, v); check("R10 sync sleeps", v, 16'h0);
    setup(EN | SRC); repeat (3) ext_pulse(); rd(1, v); check("R10 async runs", v, 16'h3);
    setup(SRC); repeat (3) ext_pulse(); rd(1, v); check("R10 disabled sleeps", v, 16'h0);
    sleep_mode = 0;

    // R11 disabled
    setup(16'h0000); ticks(10); rd(1, v); check("R11 off ticks", v, 16'h0);
    setup(SRC); repeat (3) ext_pulse(); rd(1, v); check("R11 off edges", v, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule